// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Sequencer

This block turns one pulse-width-modulated command into two complementary gate enables for a half bridge: a high-side enable that follows the command and a low-side enable that is its inverse. It never switches one side on immediately after the other side switches off. Instead it waits for sensed feedback. Before the high side may turn on, a "low-side gate is below its off threshold" flag must be seen. Before the low side may turn on, a "switch node is low" flag must be seen. Each wait ends on its flag or on a safety bound, so the dead time tracks the real power stage rather than a worst-case constant.

The command passes through a minimum-width filter first, so glitches shorter than a set number of samples never start a sequence. After the switch-node flag, the low side is held back until a minimum time after the command fell. If the switch-node flag never arrives, a timeout forces the low side on. Once on, the low side stays latched until the command rises again, so ringing on the switch node cannot chop it. Enable low or a low-side supply fault drops both outputs at once. A high-side supply fault masks only the high-side enable. All delays are parameters counted in clock cycles.

Top module: `adaptive_deadtime_seq`

## Requirements
Timing is counted in rising clock edges. Edge k0 is the first edge that samples pwm_i at a new level, provided that level is then held for at least MIN_PW edges.
- R1: While rst_n is low, ho_o and lo_o are 0 and state_o reads 0 (the shutdown code).
- R2: ho_o and lo_o are never 1 at the same time.
- R3: A new pwm_i level is accepted only after MIN_PW consecutive samples. A pulse or gap shorter than that leaves ho_o and lo_o unchanged.
- R4: On an accepted rise, lo_o falls at edge k0+MIN_PW+LO_OFF_DLY. ho_o then rises HO_ON_DLY edges after the first later edge that samples lo_gate_off_i high, and never before that flag is seen.
- R5: On an accepted fall, ho_o falls at edge k0+MIN_PW+HO_OFF_DLY. If sw_low_i is first sampled high at a later edge S before the timeout edge, lo_o rises at the later of S+LO_ON_DLY and k0+MIN_PW+LO_MIN_DLY.
- R6: If sw_low_i has not been sampled high before edge k0+MIN_PW+SW_TIMEOUT, lo_o rises at exactly that edge.
- R7: Once lo_o is 1, it stays 1 until an accepted rise or a shutdown, whatever sw_low_i does.
- R8: An accepted rise while the block waits for the switch-node flag or the low-side delay cancels the low-side turn-on: lo_o stays 0, and ho_o rises HO_ON_DLY+1 edges after edge k1+MIN_PW when lo_gate_off_i is already high (k1 being the rise's first sampling edge). An accepted fall while the block waits for lo_gate_off_i cancels the high-side turn-on and starts the low-side sequence, with the minimum-delay count starting from that fall.
- R9: An edge that samples en_i=0 or vdd_ok_i=0 drives both outputs to 0 from that edge onward. Let R be the first edge at which both inputs are sampled high again. From R the block restarts: with the command low and sw_low_i high, lo_o rises at R+1+max(LO_ON_DLY, LO_MIN_DLY). With the command high and lo_gate_off_i high, ho_o rises at R+1+HO_ON_DLY. The same restart applies after reset.
- R10: hb_ok_i low forces ho_o to 0 at once. Raising it again while the high-side phase is still active restores ho_o at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Switching command, synchronous to clk; 1 requests the high side |
| en_i | input | 1 | Run enable; 0 is shutdown |
| vdd_ok_i | input | 1 | Low-side supply above its undervoltage threshold |
| hb_ok_i | input | 1 | High-side supply above its undervoltage threshold |
| lo_gate_off_i | input | 1 | Low-side gate voltage is below its off threshold |
| sw_low_i | input | 1 | Switch node is below its low threshold |
| ho_o | output | 1 | High-side gate enable |
| lo_o | output | 1 | Low-side gate enable |
| state_o | output | 4 | Sequencer state code, 0 = shutdown |

## Verification
The bench models the power stage. The feedback flags follow the outputs with random latencies, including a latency that never ends. A scoreboard predicts the exact edge of every output change. This exposes a design that chooses the wrong bound among the switch-node delay, the minimum delay and the timeout: its low-side turn-on lands on the wrong edge. A design that lets the switch-node flag release the low side, or lets a short glitch through, shows up as an unexpected output change. Directed cases cancel a sequence halfway in each direction. A design that finishes a cancelled turn-on would raise lo_o or ho_o where no change is expected. Other directed cases drop the enable and the supply flags and check the restart timing, which catches a timer that is not cleared at shutdown.

// File: rtl/adaptive_deadtime_seq.sv
module adaptive_deadtime_seq #(
  parameter int MIN_PW     = 5,
  parameter int LO_OFF_DLY = 3,
  parameter int HO_OFF_DLY = 3,
  parameter int HO_ON_DLY  = 3,
  parameter int LO_ON_DLY  = 3,
  parameter int LO_MIN_DLY = 8,
  parameter int SW_TIMEOUT = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_i,
  input  logic       en_i,
  input  logic       vdd_ok_i,
  input  logic       hb_ok_i,
  input  logic       lo_gate_off_i,
  input  logic       sw_low_i,
  output logic       ho_o,
  output logic       lo_o,
  output logic [3:0] state_o
);

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int DMAX = imax(imax(imax(MIN_PW, LO_OFF_DLY), imax(HO_OFF_DLY, HO_ON_DLY)), LO_ON_DLY);
  localparam int FMAX = imax(SW_TIMEOUT, LO_MIN_DLY);
  localparam int CW   = $clog2(DMAX + 1);
  localparam int FW   = $clog2(FMAX + 1);

  typedef enum logic [3:0] {
    ST_OFF       = 4'd0,
    ST_LO_ON     = 4'd1,
    ST_LO_DROP   = 4'd2,
    ST_GATE_WAIT = 4'd3,
    ST_HO_DELAY  = 4'd4,
    ST_HO_ON     = 4'd5,
    ST_HO_DROP   = 4'd6,
    ST_SW_WAIT   = 4'd7,
    ST_LO_DELAY  = 4'd8
  } st_t;

  st_t st, st_n;
  logic          pwm_f;
  logic [CW-1:0] flt_cnt;
  logic [CW-1:0] dly_cnt;
  logic [FW-1:0] fall_cnt;

  wire run_ok   = en_i && vdd_ok_i;
  wire fall_min = fall_cnt >= FW'(LO_MIN_DLY);
  wire fall_tmo = fall_cnt >= FW'(SW_TIMEOUT);

  // command glitch filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_f   <= 1'b0;
      flt_cnt <= '0;
    end else if (pwm_i != pwm_f) begin
      if (flt_cnt == CW'(MIN_PW - 1)) begin
        pwm_f   <= pwm_i;
        flt_cnt <= '0;
      end else begin
        flt_cnt <= flt_cnt + CW'(1);
      end
    end else begin
      flt_cnt <= '0;
    end
  end

  // time since the accepted falling edge, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       fall_cnt <= '0;
    else if (pwm_f || st == ST_OFF)   fall_cnt <= '0;
    else if (fall_cnt != FW'(FMAX))   fall_cnt <= fall_cnt + FW'(1);
  end

  always_comb begin
    st_n = st;
    if (!run_ok) begin
      st_n = ST_OFF;
    end else begin
      case (st)
        ST_OFF:       st_n = pwm_f ? ST_GATE_WAIT : ST_SW_WAIT;
        ST_LO_ON:     if (pwm_f) st_n = ST_LO_DROP;
        ST_LO_DROP:   if (!pwm_f) st_n = ST_LO_ON;
                      else if (dly_cnt >= CW'(LO_OFF_DLY - 1)) st_n = ST_GATE_WAIT;
        ST_GATE_WAIT: if (!pwm_f) st_n = ST_SW_WAIT;
                      else if (lo_gate_off_i) st_n = ST_HO_DELAY;
        ST_HO_DELAY:  if (!pwm_f) st_n = ST_SW_WAIT;
                      else if (dly_cnt >= CW'(HO_ON_DLY - 1)) st_n = ST_HO_ON;
        ST_HO_ON:     if (!pwm_f) st_n = ST_HO_DROP;
        ST_HO_DROP:   if (pwm_f) st_n = ST_HO_ON;
                      else if (dly_cnt >= CW'(HO_OFF_DLY - 1)) st_n = ST_SW_WAIT;
        ST_SW_WAIT:   if (pwm_f) st_n = ST_GATE_WAIT;
                      else if (fall_tmo) st_n = ST_LO_ON;
                      else if (sw_low_i) st_n = ST_LO_DELAY;
        ST_LO_DELAY:  if (pwm_f) st_n = ST_GATE_WAIT;
                      else if (dly_cnt >= CW'(LO_ON_DLY - 1) && fall_min) st_n = ST_LO_ON;
        default:      st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      dly_cnt <= '0;
    end else begin
      st <= st_n;
      if (st_n != st)                  dly_cnt <= '0;
      else if (dly_cnt != CW'(DMAX))   dly_cnt <= dly_cnt + CW'(1);
    end
  end

  assign lo_o    = (st == ST_LO_ON) || (st == ST_LO_DROP);
  assign ho_o    = hb_ok_i && ((st == ST_HO_ON) || (st == ST_HO_DROP));
  assign state_o = st;

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ho_o && lo_o));

  assert_gate_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HO_DELAY && $past(st) == ST_GATE_WAIT) |-> $past(lo_gate_off_i));

  assert_lo_min_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_o) |-> fall_cnt >= FW'(LO_MIN_DLY));

  assert_sw_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && !pwm_f && st == ST_SW_WAIT && fall_tmo) |=> lo_o);

  assert_lo_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_o && run_ok && !pwm_f) |=> lo_o);

  assert_shutdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> (!ho_o && !lo_o));

endmodule

// File: tb/adaptive_deadtime_seq_tb_top.sv
module adaptive_deadtime_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_PW = 5, LO_OFF = 3, HO_OFF = 3, HO_ON = 3, LO_ON = 3, LO_MIN = 8, SW_TO = 25;
  localparam int NEVER = 1000000;

  logic clk = 1'b0;
  logic rst_n, pwm_i, en_i, vdd_ok_i, hb_ok_i, lo_gate_off_i, sw_low_i;
  logic ho_o, lo_o;
  logic [3:0] state_o;

  adaptive_deadtime_seq #(
    .MIN_PW(MIN_PW), .LO_OFF_DLY(LO_OFF), .HO_OFF_DLY(HO_OFF), .HO_ON_DLY(HO_ON),
    .LO_ON_DLY(LO_ON), .LO_MIN_DLY(LO_MIN), .SW_TIMEOUT(SW_TO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm_i), .en_i(en_i), .vdd_ok_i(vdd_ok_i),
    .hb_ok_i(hb_ok_i), .lo_gate_off_i(lo_gate_off_i), .sw_low_i(sw_low_i),
    .ho_o(ho_o), .lo_o(lo_o), .state_o(state_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, overlaps = 0;
  bit done = 0, mon_en = 0;

  // power-stage model: flags follow the outputs after a latency
  int g_lat = 1, s_lat = 1, gcnt = 0, scnt = 0;
  bit sw_ovr = 0, sw_ovr_val = 0;
  always @(negedge clk) begin
    gcnt = lo_o ? 0 : ((gcnt < 2*NEVER) ? gcnt + 1 : gcnt);
    scnt = ho_o ? 0 : ((scnt < 2*NEVER) ? scnt + 1 : scnt);
    lo_gate_off_i = (gcnt >= g_lat);
    sw_low_i = sw_ovr ? sw_ovr_val : (scnt >= s_lat);
  end

  // scoreboard
  bit    q_ho[$];
  bit    q_val[$];
  int    q_cyc[$];
  string q_req[$];

  task automatic expect_ev(bit is_ho, bit val, int c, string req);
    q_ho.push_back(is_ho); q_val.push_back(val); q_cyc.push_back(c); q_req.push_back(req);
  endtask

  function automatic string nm(bit is_ho);
    return is_ho ? "ho_o" : "lo_o";
  endfunction

  task automatic compare(bit is_ho, bit val);
    checks++;
    if (q_ho.size() == 0) begin
      errors++;
      $display("FAIL R7/R3/R8: unexpected %s->%0b at cycle %0d, expected no change", nm(is_ho), val, cyc);
    end else begin
      bit eh = q_ho.pop_front(); bit ev = q_val.pop_front();
      int ec = q_cyc.pop_front(); string er = q_req.pop_front();
      if (eh != is_ho || ev != val || ec != cyc) begin
        errors++;
        $display("FAIL %s: %s->%0b at cycle %0d, expected %s->%0b at cycle %0d",
                 er, nm(is_ho), val, cyc, nm(eh), ev, ec);
      end
    end
  endtask

  logic ho_prev = 1'b0, lo_prev = 1'b0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (ho_o && lo_o) overlaps++;
      if (ho_o !== ho_prev) compare(1'b1, ho_o);
      if (lo_o !== lo_prev) compare(1'b0, lo_o);
    end
    ho_prev = ho_o;
    lo_prev = lo_o;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, int act, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic rise_phase(int g, int extra);
    int k0, l;
    g_lat = g;
    pwm_i = 1'b1;
    k0 = cyc + 1;
    l = k0 + MIN_PW + LO_OFF;
    expect_ev(1'b0, 1'b0, l, "R4");
    expect_ev(1'b1, 1'b1, l + g + HO_ON, "R4");
    tick(MIN_PW + LO_OFF + g + HO_ON + 3 + extra);
  endtask

  task automatic fall_phase(int s, int extra);
    int k0, h, tto, a, b;
    s_lat = s;
    pwm_i = 1'b0;
    k0 = cyc + 1;
    h = k0 + MIN_PW + HO_OFF;
    tto = k0 + MIN_PW + SW_TO;
    expect_ev(1'b1, 1'b0, h, "R5");
    if (s >= NEVER || h + s >= tto) expect_ev(1'b0, 1'b1, tto, "R6");
    else begin
      a = h + s + LO_ON;
      b = k0 + MIN_PW + LO_MIN;
      if (b > a) expect_ev(1'b0, 1'b1, b, "R5");
      else       expect_ev(1'b0, 1'b1, a, "R5");
    end
    tick(MIN_PW + SW_TO + LO_ON + 5 + extra);
  endtask

  initial begin
    int m, k1, a, b;
    rst_n = 1'b0; pwm_i = 1'b0; en_i = 1'b1; vdd_ok_i = 1'b1; hb_ok_i = 1'b1;
    tick(5);
    check(ho_o == 1'b0, "R1 ho_o in reset", ho_o, 0);
    check(lo_o == 1'b0, "R1 lo_o in reset", lo_o, 0);
    check(state_o == 4'd0, "R1 state_o in reset", state_o, 0);
    mon_en = 1;
    rst_n = 1'b1;
    m = cyc + 1;
    expect_ev(1'b0, 1'b1, m + 1 + ((LO_ON > LO_MIN) ? LO_ON : LO_MIN), "R9 startup");
    tick(30);

    // randomised phases
    for (int i = 0; i < 30; i++) begin
      int r, s;
      rise_phase($urandom_range(1, 6), $urandom_range(0, 8));
      r = $urandom_range(0, 3);
      if (r == 0)      s = $urandom_range(1, 2);
      else if (r == 1) s = NEVER;
      else             s = $urandom_range(3, 20);
      fall_phase(s, $urandom_range(0, 8));
    end

    // directed bounds: minimum delay and timeout
    rise_phase(1, 0);
    fall_phase(1, 0);
    rise_phase(2, 0);
    fall_phase(NEVER, 0);

    // R3: short high glitch while LO on
    pwm_i = 1'b1; tick(MIN_PW - 1); pwm_i = 1'b0; tick(20);
    check(lo_o == 1'b1, "R3 lo_o after short glitch", lo_o, 1);

    // R7: switch-node ringing while LO on
    sw_ovr = 1;
    for (int i = 0; i < 20; i++) begin
      sw_ovr_val = ~sw_ovr_val;
      tick(1);
    end
    sw_ovr = 0;
    check(lo_o == 1'b1, "R7 lo_o held through ringing", lo_o, 1);

    // R3: short low glitch while HO on
    rise_phase(1, 0);
    pwm_i = 1'b0; tick(MIN_PW - 1); pwm_i = 1'b1; tick(20);
    check(ho_o == 1'b1, "R3 ho_o after short glitch", ho_o, 1);

    // R8: rise while waiting for switch node
    s_lat = NEVER; g_lat = 1;
    pwm_i = 1'b0;
    expect_ev(1'b1, 1'b0, cyc + 1 + MIN_PW + HO_OFF, "R8");
    tick(MIN_PW + HO_OFF + 2);
    pwm_i = 1'b1;
    k1 = cyc + 1;
    expect_ev(1'b1, 1'b1, k1 + MIN_PW + 1 + HO_ON, "R8");
    tick(40);
    check(lo_o == 1'b0, "R8 lo_o stayed off", lo_o, 0);
    check(ho_o == 1'b1, "R8 ho_o back on", ho_o, 1);

    // R8: fall while waiting for gate flag
    fall_phase(3, 0);
    g_lat = NEVER;
    pwm_i = 1'b1;
    expect_ev(1'b0, 1'b0, cyc + 1 + MIN_PW + LO_OFF, "R8");
    tick(12);
    s_lat = 1;
    pwm_i = 1'b0;
    k1 = cyc + 1;
    a = k1 + MIN_PW + 1 + LO_ON;
    b = k1 + MIN_PW + LO_MIN;
    expect_ev(1'b0, 1'b1, (a > b) ? a : b, "R8");
    tick(40);
    check(ho_o == 1'b0, "R8 ho_o never rose", ho_o, 0);
    check(lo_o == 1'b1, "R8 lo_o on", lo_o, 1);
    g_lat = 1;

    // R9: enable drop while LO on, then restart
    en_i = 1'b0;
    expect_ev(1'b0, 1'b0, cyc + 1, "R9");
    tick(10);
    check(!ho_o && !lo_o, "R9 outputs in shutdown", {ho_o, lo_o}, 0);
    en_i = 1'b1;
    m = cyc + 1;
    expect_ev(1'b0, 1'b1, m + 1 + ((LO_ON > LO_MIN) ? LO_ON : LO_MIN), "R9");
    tick(30);

    // R9: supply fault while HO on, then restart
    rise_phase(1, 0);
    vdd_ok_i = 1'b0;
    expect_ev(1'b1, 1'b0, cyc + 1, "R9");
    tick(10);
    check(!ho_o && !lo_o, "R9 outputs in supply fault", {ho_o, lo_o}, 0);
    vdd_ok_i = 1'b1;
    m = cyc + 1;
    expect_ev(1'b1, 1'b1, m + 1 + HO_ON, "R9");
    tick(20);

    // R10: high-side supply mask
    hb_ok_i = 1'b0;
    expect_ev(1'b1, 1'b0, cyc + 1, "R10");
    tick(5);
    check(ho_o == 1'b0, "R10 ho_o masked", ho_o, 0);
    hb_ok_i = 1'b1;
    expect_ev(1'b1, 1'b1, cyc + 1, "R10");
    tick(5);
    check(ho_o == 1'b1, "R10 ho_o restored", ho_o, 1);

    fall_phase(4, 0);
    tick(5);

    check(q_ho.size() == 0, "R4/R5 all expected transitions seen", q_ho.size(), 0);
    check(overlaps == 0, "R2 no overlap cycles", overlaps, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule